// File: doc/BRIEF.md
# Feature Header List Walker

This block enumerates the hardware features of a memory-mapped region. A one-cycle `start` pulse gives it the byte address of the first 64-bit feature header. It then follows the chain of headers by issuing single 64-bit reads, one at a time. For each header it reads the first word and extracts the type, version, revision, feature number, end-of-list flag and link. Depending on the version and type, it also reads the 128-bit identifier. Version-1 headers add two more words: the register-location word and the size/group word. A version-1 header may also carry a second, inner chain of parameter blocks. The walker follows that chain only to count its blocks.

Each discovered feature is written into a small table. The host reads the table combinationally by index once `done` is high, and `feat_count` gives the number of valid entries. A malformed list stops the walk with `err` set and a two-bit cause in `err_code`. The read port is a valid/ready pair for the request and a second pair for the response. The request holds its address stable until accepted. The response is taken only while the walker waits for it, so the memory side applies back-pressure simply by delaying `rd_req_ready` or `rd_rsp_valid`.

Top module: `fhl_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `done` and `err` are 0, `feat_count` is 0 and `rd_req_valid` is 0.
- R2: `start` is taken only while `busy` is 0. A pulse while busy does not change the walk or its results. A request keeps `rd_req_valid` and `rd_req_addr` stable until `rd_req_ready`. At most one read is outstanding: `rd_rsp_ready` is high only while `rd_req_valid` is low.
- R3: Header word fields are: type 63:60, version 59:52, end-of-list 40, next 39:16, revision 15:12, feature number 11:0. The table holds type, number and revision as read.
- R4: The next header is at current header address + next (bytes). Every read address is 8-byte aligned. The walk ends after a header whose end-of-list bit is 1.
- R5: The identifier is read as low word at header+0x08 and high word at header+0x10. It is read for every version-1 header, and for version-0 headers only when the type is 1 or 4. Otherwise the stored identifier is 0.
- R6: For version 1, word header+0x18 sets the register base. When bit 0 = 1 the base is that word with bit 0 cleared (absolute). When bit 0 = 0 the base is header address + that word with bit 0 cleared. For version 0 the base is the header address.
- R7: For version 1, the stored register size is bits 63:32 of header+0x20, and bit 31 of that word says parameter blocks are present. For version 0 the stored size is the header's next field.
- R8: Parameter blocks start at header+0x28. Block fields are: next 63:35 (in 8-byte words), end-of-parameters 32. Each block counts once into the entry's parameter count, and a block with end-of-parameters ends the inner walk.
- R9: Errors stop the walk with `err`=1 and `done`=1. A zero header link without end-of-list, or a zero block link without end-of-parameters, gives code 1. A header link with nonzero bits 2:0 gives code 2; in both header-link cases (codes 1 and 2) the current entry is stored. A further header after `MAX_FEAT` entries gives code 3. More than `MAX_PARAM` blocks also gives code 3, and that entry is not stored.
- R10: A header version other than 0 or 1 is decoded as version 0, and its entry has the warning bit set.
- R11: `busy` is 1 from the cycle after an accepted start until the walk ends. `done` then stays 1 until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| base_addr | input | AW | Byte address of first header, 8-byte aligned |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished (held) |
| err | output | 1 | Walk ended on a malformed list |
| err_code | output | 2 | 1 zero link, 2 misaligned link, 3 limit exceeded |
| feat_count | output | FCW | Number of valid table entries |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Walker takes read data |
| rd_rsp_data | input | 64 | Read data |
| tab_idx | input | FIW | Table entry to read |
| tab_type | output | 4 | Entry type |
| tab_id | output | 12 | Entry feature number |
| tab_rev | output | 4 | Entry revision |
| tab_warn | output | 1 | Entry version was unknown |
| tab_base | output | AW | Entry register base |
| tab_size | output | 32 | Entry register size |
| tab_nparam | output | 8 | Entry parameter block count |
| tab_guid | output | 128 | Entry identifier |

## Verification
The bench runs a four-header list that mixes a version-1 relative base with parameters, a version-1 absolute base, a version-0 header that carries an identifier and an unknown version. A design that confused the byte and word link units, or the absolute and relative encodings, would store wrong bases or parameter counts. Separate lists end on a misaligned link, a zero link, too many headers, too many blocks and a zero block link. A wrong limit comparison shows as an off-by-one entry count or a missing error code. The memory model stalls both handshakes pseudo-randomly, and a start pulse is sent mid-walk. A design that dropped a held request or restarted while busy would produce a wrong table.

// File: rtl/fhl_pkg.sv
package fhl_pkg;
  typedef enum logic [2:0] {PH_HDR, PH_GLO, PH_GHI, PH_LOC, PH_SZ, PH_PRM} phase_e;
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_FIN} state_e;
  typedef enum logic [1:0] {E_NONE = 2'd0, E_ZERO = 2'd1, E_ALIGN = 2'd2, E_LIMIT = 2'd3} err_e;

  localparam logic [3:0] TYPE_ACCEL = 4'd1;
  localparam logic [3:0] TYPE_MGMT  = 4'd4;

  typedef struct packed {
    logic [3:0]  typ;
    logic [7:0]  ver;
    logic        eol;
    logic [23:0] nxt;
    logic [3:0]  rev;
    logic [11:0] id;
  } hdr_t;

  typedef struct packed {
    logic [28:0] nxt;
    logic        eop;
  } prm_t;

  typedef struct packed {
    logic [3:0]   typ;
    logic [11:0]  id;
    logic [3:0]   rev;
    logic         warn;
    logic [31:0]  rsize;
    logic [7:0]   nparam;
    logic [127:0] guid;
  } meta_t;
endpackage

// File: rtl/fhl_word_dec.sv
module fhl_word_dec
  import fhl_pkg::*;
(
  input  logic [63:0] word,
  output hdr_t        hdr,
  output prm_t        prm
);
  always_comb begin
    hdr.typ = word[63:60];
    hdr.ver = word[59:52];
    hdr.eol = word[40];
    hdr.nxt = word[39:16];
    hdr.rev = word[15:12];
    hdr.id  = word[11:0];
    prm.nxt = word[63:35];
    prm.eop = word[32];
  end
endmodule

// File: rtl/fhl_table.sv
module fhl_table
  import fhl_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 48,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  meta_t         wmeta,
  input  logic [AW-1:0] wbase,
  input  logic [IW-1:0] raddr,
  output meta_t         rmeta,
  output logic [AW-1:0] rbase
);
  meta_t         meta_q [DEPTH];
  logic [AW-1:0] base_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we && waddr == IW'(g)) begin
        meta_q[g] <= wmeta;
        base_q[g] <= wbase;
      end
    end
  end

  assign rmeta = meta_q[raddr];
  assign rbase = base_q[raddr];
endmodule

// File: rtl/fhl_walker.sv
module fhl_walker
  import fhl_pkg::*;
#(
  parameter int AW        = 48,
  parameter int MAX_FEAT  = 8,
  parameter int MAX_PARAM = 15,
  localparam int FCW      = $clog2(MAX_FEAT + 1),
  localparam int FIW      = $clog2(MAX_FEAT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  base_addr,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [1:0]     err_code,
  output logic [FCW-1:0] feat_count,
  output logic           rd_req_valid,
  input  logic           rd_req_ready,
  output logic [AW-1:0]  rd_req_addr,
  input  logic           rd_rsp_valid,
  output logic           rd_rsp_ready,
  input  logic [63:0]    rd_rsp_data,
  input  logic [FIW-1:0] tab_idx,
  output logic [3:0]     tab_type,
  output logic [11:0]    tab_id,
  output logic [3:0]     tab_rev,
  output logic           tab_warn,
  output logic [AW-1:0]  tab_base,
  output logic [31:0]    tab_size,
  output logic [7:0]     tab_nparam,
  output logic [127:0]   tab_guid
);
  state_e        state;
  phase_e        phase;
  logic [AW-1:0] hdr_addr, prm_addr, base_r;
  hdr_t          hdr_r, dec_h;
  prm_t          dec_p;
  logic          v1_r, warn_r;
  logic [31:0]   size_r;
  logic [127:0]  guid_r;
  logic [7:0]    pcnt;
  logic [AW-1:0] loc_val;
  meta_t         wmeta, rmeta;

  fhl_word_dec u_dec (.word(rd_rsp_data), .hdr(dec_h), .prm(dec_p));

  assign loc_val = {rd_rsp_data[AW-1:1], 1'b0};

  always_comb begin
    unique case (phase)
      PH_GLO:  rd_req_addr = hdr_addr + AW'(8);
      PH_GHI:  rd_req_addr = hdr_addr + AW'(16);
      PH_LOC:  rd_req_addr = hdr_addr + AW'(24);
      PH_SZ:   rd_req_addr = hdr_addr + AW'(32);
      PH_PRM:  rd_req_addr = prm_addr;
      default: rd_req_addr = hdr_addr;
    endcase
  end

  assign rd_req_valid = (state == S_REQ);
  assign rd_rsp_ready = (state == S_RSP);
  assign busy         = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; phase <= PH_HDR; done <= 1'b0; err <= 1'b0;
      err_code <= E_NONE; feat_count <= '0; hdr_addr <= '0; prm_addr <= '0;
      hdr_r <= '0; v1_r <= 1'b0; warn_r <= 1'b0; base_r <= '0;
      size_r <= '0; guid_r <= '0; pcnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state <= S_REQ; phase <= PH_HDR; hdr_addr <= base_addr;
          done <= 1'b0; err <= 1'b0; err_code <= E_NONE; feat_count <= '0;
        end
        S_REQ: if (rd_req_ready) state <= S_RSP;
        S_RSP: if (rd_rsp_valid) begin
          state <= S_REQ;
          unique case (phase)
            PH_HDR: begin
              hdr_r <= dec_h; v1_r <= (dec_h.ver == 8'd1); warn_r <= (dec_h.ver > 8'd1);
              base_r <= hdr_addr; size_r <= 32'(dec_h.nxt); guid_r <= '0; pcnt <= '0;
              if (dec_h.ver == 8'd1 || dec_h.typ == TYPE_ACCEL || dec_h.typ == TYPE_MGMT)
                phase <= PH_GLO;
              else state <= S_FIN;
            end
            PH_GLO: begin guid_r[63:0] <= rd_rsp_data; phase <= PH_GHI; end
            PH_GHI: begin
              guid_r[127:64] <= rd_rsp_data;
              if (v1_r) phase <= PH_LOC; else state <= S_FIN;
            end
            PH_LOC: begin
              base_r <= rd_rsp_data[0] ? loc_val : hdr_addr + loc_val;
              phase  <= PH_SZ;
            end
            PH_SZ: begin
              size_r <= rd_rsp_data[63:32];
              if (rd_rsp_data[31]) begin
                prm_addr <= hdr_addr + AW'(40); phase <= PH_PRM;
              end else state <= S_FIN;
            end
            default: begin
              if (pcnt == 8'(MAX_PARAM)) begin
                state <= S_IDLE; done <= 1'b1; err <= 1'b1; err_code <= E_LIMIT;
              end else begin
                pcnt <= pcnt + 8'd1;
                if (dec_p.eop) state <= S_FIN;
                else if (dec_p.nxt == '0) begin
                  state <= S_IDLE; done <= 1'b1; err <= 1'b1; err_code <= E_ZERO;
                end else prm_addr <= prm_addr + AW'({dec_p.nxt, 3'b000});
              end
            end
          endcase
        end
        default: begin
          feat_count <= feat_count + FCW'(1);
          phase      <= PH_HDR;
          if (hdr_r.eol) begin
            state <= S_IDLE; done <= 1'b1;
          end else if (hdr_r.nxt == '0 || hdr_r.nxt[2:0] != 3'd0 ||
                       feat_count + FCW'(1) == FCW'(MAX_FEAT)) begin
            state <= S_IDLE; done <= 1'b1; err <= 1'b1;
            err_code <= (hdr_r.nxt == '0) ? E_ZERO :
                        (hdr_r.nxt[2:0] != 3'd0) ? E_ALIGN : E_LIMIT;
          end else begin
            state <= S_REQ; hdr_addr <= hdr_addr + AW'(hdr_r.nxt);
          end
        end
      endcase
    end
  end

  always_comb begin
    wmeta.typ    = hdr_r.typ;
    wmeta.id     = hdr_r.id;
    wmeta.rev    = hdr_r.rev;
    wmeta.warn   = warn_r;
    wmeta.rsize  = size_r;
    wmeta.nparam = pcnt;
    wmeta.guid   = guid_r;
  end

  fhl_table #(.DEPTH(MAX_FEAT), .AW(AW)) u_tab (
    .clk(clk), .we(state == S_FIN), .waddr(feat_count[FIW-1:0]),
    .wmeta(wmeta), .wbase(base_r), .raddr(tab_idx), .rmeta(rmeta), .rbase(tab_base)
  );

  assign tab_type   = rmeta.typ;
  assign tab_id     = rmeta.id;
  assign tab_rev    = rmeta.rev;
  assign tab_warn   = rmeta.warn;
  assign tab_size   = rmeta.rsize;
  assign tab_nparam = rmeta.nparam;
  assign tab_guid   = rmeta.guid;
endmodule

module fhl_walker_chk #(
  parameter int AW       = 48,
  parameter int MAX_FEAT = 8,
  localparam int FCW     = $clog2(MAX_FEAT + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic [FCW-1:0] feat_count,
  input logic           rd_req_valid,
  input logic           rd_req_ready,
  input logic [AW-1:0]  rd_req_addr,
  input logic           rd_rsp_ready
);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready));
  p_addr_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr[2:0] == 3'd0);
  p_err_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !busy);
  p_count_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    feat_count <= FCW'(MAX_FEAT));
  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req_valid && !rd_rsp_ready);
  p_busy_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || done);
endmodule

bind fhl_walker fhl_walker_chk #(.AW(AW), .MAX_FEAT(MAX_FEAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .feat_count(feat_count), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .rd_rsp_ready(rd_rsp_ready)
);

// File: tb/fhl_walker_tb.sv
module fhl_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, MAX_FEAT = 4, MAX_PARAM = 3;
  localparam int FCW = $clog2(MAX_FEAT + 1), FIW = $clog2(MAX_FEAT);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic busy, done, err;
  logic [1:0] err_code;
  logic [FCW-1:0] feat_count;
  logic rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [AW-1:0] rd_req_addr;
  logic [63:0] rd_rsp_data;
  logic [FIW-1:0] tab_idx = '0;
  logic [3:0] tab_type, tab_rev;
  logic [11:0] tab_id;
  logic tab_warn;
  logic [AW-1:0] tab_base;
  logic [31:0] tab_size;
  logic [7:0] tab_nparam;
  logic [127:0] tab_guid;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fhl_walker #(.AW(AW), .MAX_FEAT(MAX_FEAT), .MAX_PARAM(MAX_PARAM)) u_dut (.*);

  typedef struct packed {
    logic [3:0] typ; logic [11:0] id; logic [3:0] rev; logic warn;
    logic [AW-1:0] base; logic [31:0] size; logic [7:0] np; logic [127:0] guid;
  } exp_t;
  exp_t exp_q[$];
  int tests = 0, fails = 0;

  // memory model with pseudo-random stalls on both handshakes
  logic [63:0] mem [int unsigned];
  logic [7:0] lfsr;
  logic pend;
  logic [1:0] dly;
  logic [AW-1:0] paddr;

  function automatic logic [63:0] rdm(input logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 8'h5a; rd_req_ready <= 1'b0; rd_rsp_valid <= 1'b0; rd_rsp_data <= '0;
      pend <= 1'b0; dly <= '0; paddr <= '0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rd_req_ready <= lfsr[0] | lfsr[1];
      if (rd_req_valid && rd_req_ready) begin
        pend <= 1'b1; paddr <= rd_req_addr; dly <= lfsr[3:2];
      end
      if (pend && !rd_rsp_valid) begin
        if (dly != 2'd0) dly <= dly - 2'd1;
        else begin rd_rsp_valid <= 1'b1; rd_rsp_data <= rdm(paddr); end
      end
      if (rd_rsp_valid && rd_rsp_ready) begin rd_rsp_valid <= 1'b0; pend <= 1'b0; end
    end
  end

  function automatic logic [63:0] hw(input logic [3:0] t, input logic [7:0] v, input logic e,
                                     input logic [23:0] n, input logic [3:0] r, input logic [11:0] i);
    return {t, v, 11'd0, e, n, r, i};
  endfunction
  function automatic logic [63:0] pw(input logic [28:0] n, input logic eop, input logic [15:0] i);
    return {n, 2'b00, eop, 16'd1, i};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // driver side: push expected entry
  task automatic push_exp(input logic [3:0] t, input logic [11:0] i, input logic [3:0] r,
                          input logic w, input logic [AW-1:0] b, input logic [31:0] s,
                          input logic [7:0] n, input logic [127:0] g);
    exp_t e;
    e.typ = t; e.id = i; e.rev = r; e.warn = w; e.base = b; e.size = s; e.np = n; e.guid = g;
    exp_q.push_back(e);
  endtask

  task automatic run(input logic [AW-1:0] a, input bit poke);
    int cyc = 0;
    @(negedge clk); base_addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !done, "R11", "busy after start", {busy, done}, 2'b10);
    if (poke) begin
      repeat (5) @(negedge clk);
      base_addr = 32'h2000; start = 1'b1;   // R2: must be ignored
      @(negedge clk); start = 1'b0;
    end
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    if (!done) begin fails++; tests++; $display("FAIL R11 watchdog actual=0 expected=1"); end
  endtask

  // monitor side: pop and compare
  task automatic monitor(input string req, input logic e, input logic [1:0] code, input int cnt);
    chk(err == e && (!e || err_code == code) && !busy, req, "err/code",
        {err, err_code}, {e, code});
    chk(feat_count == FCW'(cnt), req, "feat_count", feat_count, cnt);
    for (int k = 0; k < cnt; k++) begin
      exp_t x, a;
      x = exp_q.pop_front();
      tab_idx = FIW'(k); #1;
      a.typ = tab_type; a.id = tab_id; a.rev = tab_rev; a.warn = tab_warn; a.base = tab_base;
      a.size = tab_size; a.np = tab_nparam; a.guid = tab_guid;
      chk(a == x, req, $sformatf("entry %0d", k), a, x);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && feat_count == 0 && !rd_req_valid, "R1", "reset",
        {busy, done, err, rd_req_valid}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !rd_req_valid, "R1", "idle after reset", {busy, done}, 2'b0);

    // list A: R3 R4 R5 R6 R7 R8 R10
    mem[32'h1000] = hw(4'd3, 8'd1, 1'b0, 24'h100, 4'd2, 12'h012);
    mem[32'h1008] = 64'h1111_2222_3333_4444; mem[32'h1010] = 64'h5555_6666_7777_8888;
    mem[32'h1018] = 64'h40;
    mem[32'h1020] = (64'h80 << 32) | (64'd1 << 31) | (64'd5 << 16) | 64'd1;
    mem[32'h1028] = pw(29'd2, 1'b0, 16'h10);
    mem[32'h1038] = pw(29'd1, 1'b1, 16'h11);
    mem[32'h1100] = hw(4'd2, 8'd1, 1'b0, 24'h80, 4'd3, 12'h034);
    mem[32'h1108] = 64'hAAAA; mem[32'h1110] = 64'hBBBB;
    mem[32'h1118] = 64'hABCD_0001; mem[32'h1120] = 64'h1000 << 32;
    mem[32'h1180] = hw(4'd1, 8'd0, 1'b0, 24'h180, 4'd1, 12'h005);
    mem[32'h1188] = 64'hC0C0; mem[32'h1190] = 64'hD0D0;
    mem[32'h1300] = hw(4'd3, 8'd7, 1'b1, 24'h400, 4'd4, 12'h009);
    push_exp(4'd3, 12'h012, 4'd2, 1'b0, 32'h1040, 32'h80, 8'd2,
             {64'h5555_6666_7777_8888, 64'h1111_2222_3333_4444});   // R6 relative, R8
    push_exp(4'd2, 12'h034, 4'd3, 1'b0, 32'hABCD_0000, 32'h1000, 8'd0,
             {64'hBBBB, 64'hAAAA});                                  // R6 absolute, R7
    push_exp(4'd1, 12'h005, 4'd1, 1'b0, 32'h1180, 32'h180, 8'd0,
             {64'hD0D0, 64'hC0C0});                                  // R5 v0 type 1
    push_exp(4'd3, 12'h009, 4'd4, 1'b1, 32'h1300, 32'h400, 8'd0, 128'd0); // R10 warn
    run(32'h1000, 1'b1);
    monitor("R3 R4 R2", 1'b0, 2'd0, 4);

    // R9 misaligned link, entry kept
    mem[32'h2000] = hw(4'd3, 8'd0, 1'b0, 24'h44, 4'd0, 12'h001);
    push_exp(4'd3, 12'h001, 4'd0, 1'b0, 32'h2000, 32'h44, 8'd0, 128'd0);
    run(32'h2000, 1'b0);
    monitor("R9 align", 1'b1, 2'd2, 1);

    // R9 zero link; R5 v0 type 2 has no identifier
    mem[32'h3000] = hw(4'd2, 8'd0, 1'b0, 24'h0, 4'd1, 12'h002);
    push_exp(4'd2, 12'h002, 4'd1, 1'b0, 32'h3000, 32'h0, 8'd0, 128'd0);
    run(32'h3000, 1'b0);
    monitor("R9 zero R5", 1'b1, 2'd1, 1);

    // R9 header limit
    for (int k = 0; k < 5; k++) begin
      mem[32'h4000 + 8 * k] = hw(4'd3, 8'd0, 1'b0, 24'h8, 4'd0, 12'(k));
      if (k < 4) push_exp(4'd3, 12'(k), 4'd0, 1'b0, 32'(32'h4000 + 8 * k), 32'h8, 8'd0, 128'd0);
    end
    run(32'h4000, 1'b0);
    monitor("R9 feat limit", 1'b1, 2'd3, 4);

    // R9 parameter limit: 4 blocks, limit 3, entry dropped
    mem[32'h5000] = hw(4'd3, 8'd1, 1'b1, 24'h100, 4'd0, 12'h007);
    mem[32'h5020] = (64'h10 << 32) | (64'd1 << 31);
    for (int k = 0; k < 4; k++) mem[32'h5028 + 16 * k] = pw(29'd2, 1'b0, 16'(k));
    run(32'h5000, 1'b0);
    monitor("R9 R8 param limit", 1'b1, 2'd3, 0);

    // R9 zero parameter link
    mem[32'h6000] = hw(4'd3, 8'd1, 1'b1, 24'h100, 4'd0, 12'h008);
    mem[32'h6020] = (64'h10 << 32) | (64'd1 << 31);
    mem[32'h6028] = pw(29'd0, 1'b0, 16'h1);
    run(32'h6000, 1'b0);
    monitor("R9 param zero", 1'b1, 2'd1, 0);

    chk(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL R11 global watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule